// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a small two-bit-per-pixel cursor image over the pixel stream of a display pipeline. For every pixel it receives the current beam coordinate and the underlying 24-bit colour. It returns one of four things: the unchanged pixel, one of two programmable cursor colours, or the bitwise complement of the pixel. The result appears one clock later.

A host loads the cursor bitmap one byte at a time through an index register and a data port. The index advances by one after each access. A second way to write the index also fetches the byte at the new index into a prefetch register. The cursor is placed by giving the screen coordinate of its hotspot and, separately, the offset of that hotspot inside the 64x64 image. Bitmap writes are refused while the cursor is shown. A refused write sets a sticky error flag. Beam timing, palette lookup and digital-to-analog conversion belong to other blocks.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid and out_rgb are 0, wr_err is 0, and the enable bit reads back 0.
- R2: While the enable bit is clear, out_rgb equals pix_rgb one clock earlier, and out_valid equals pix_valid one clock earlier.
- R3: The cursor covers a 64x64 square. Its top-left corner is at (posx - hotx, posy - hoty), which may be negative. Beam positions outside the square pass the pixel unchanged.
- R4: When the cursor is enabled, a covered pixel depends on its 2-bit code. Code 0 gives colour 0 and code 1 gives colour 1. Code 2 gives the input pixel. Code 3 gives the bitwise inverse of all 24 bits. Pixels are packed red[23:16], green[15:8], blue[7:0].
- R5: The bitmap is row-major, 16 bytes per row. Row r, column c sits in byte r*16 + c/4, bits 2*(c%4)+1 : 2*(c%4). The leftmost pixel uses the low bit pair.
- R6: A host write to the data port (address 13) while the cursor is disabled stores wdata[7:0] at the index and then adds one to the index.
- R7: A host read of the data port puts the byte at the index on host_rdata one clock after the strobe, then adds one to the index.
- R8: A write to address 12 loads the index from wdata[13:0] and loads the prefetch register with the byte at that index. A read of address 14 returns the prefetch register one clock later.
- R9: A data-port write made while the cursor is enabled leaves both the bitmap and the index unchanged and sets wr_err. wr_err stays set until a write to address 4 with wdata[1] = 1.
- R10: The host address map is as follows. Addresses 0 and 1 hold posx and posy (11 bits). Addresses 2 and 3 hold hotx and hoty (6 bits). Address 4 is control: bit 0 is enable, and writing bit 1 clears the error; a read returns {err, enable} in bits 1:0. Addresses 5 to 7 hold colour 0 red, green and blue. Addresses 8 to 10 hold colour 1 red, green and blue. Address 11 is the plain index write.
- R11: When pix_valid is low, out_valid goes low one clock later, and out_rgb carries pix_rgb unchanged even over the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (ignored when host_we is high) |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 8 | Host read data, valid one clock after host_re |
| wr_err | output | 1 | Sticky flag: a bitmap write was refused |
| pix_valid | input | 1 | Active pixel qualifier |
| beam_x | input | 11 | Current beam column |
| beam_y | input | 11 | Current beam row |
| pix_rgb | input | 24 | Underlying pixel colour |
| out_valid | output | 1 | Registered pixel qualifier |
| out_rgb | output | 24 | Registered output pixel |

## Verification
The bench builds the block with its default parameters: a 64-pixel cursor, 11-bit coordinates and a 14-bit index. With these values it can reach both edges of the square at columns and rows 0 and 63, and the first position outside each edge. A hotspot offset larger than the position pushes the left edge below zero, which exercises the signed hit test. A full 1024-byte bitmap load reaches the top of the memory, where the bench places a two-byte write run.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        CODE_C0     = 2'd0,
        CODE_C1     = 2'd1,
        CODE_CLEAR  = 2'd2,
        CODE_INVERT = 2'd3
    } spr_code_e;

    typedef enum logic [3:0] {
        A_POS_X    = 4'd0,
        A_POS_Y    = 4'd1,
        A_HOT_X    = 4'd2,
        A_HOT_Y    = 4'd3,
        A_CTRL     = 4'd4,
        A_C0_R     = 4'd5,
        A_C0_G     = 4'd6,
        A_C0_B     = 4'd7,
        A_C1_R     = 4'd8,
        A_C1_G     = 4'd9,
        A_C1_B     = 4'd10,
        A_INDEX    = 4'd11,
        A_INDEX_PF = 4'd12,
        A_DATA     = 4'd13,
        A_PREFETCH = 4'd14
    } host_addr_e;

    function automatic rgb_t rgb_invert(input rgb_t p);
        return rgb_t'(~p);
    endfunction

endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W-1:0] pix_addr,
    output logic [7:0]        pix_byte,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    assign pix_byte  = mem[pix_addr];
    assign host_byte = mem[host_addr];
endmodule

// File: rtl/cursor_host_regs.sv
module cursor_host_regs
    import cursor_ovl_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int HOT_W   = 6,
    parameter int IDX_W   = 14,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [3:0]         host_addr,
    input  logic [15:0]        host_wdata,
    output logic [7:0]         host_rdata,
    output logic               wr_err,
    output logic               spr_en,
    output logic [IDX_W-1:0]   spr_idx,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic [HOT_W-1:0]   hot_x,
    output logic [HOT_W-1:0]   hot_y,
    output rgb_t               col0,
    output rgb_t               col1,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [7:0]         mem_wdata,
    output logic [ADDR_W-1:0]  mem_raddr,
    input  logic [7:0]         mem_rbyte
);
    logic [7:0] prefetch;
    logic       wr_data_hit;
    logic       pf_load;

    assign wr_data_hit = host_we && (host_addr == A_DATA);
    assign pf_load     = host_we && (host_addr == A_INDEX_PF);
    assign mem_we      = wr_data_hit && !spr_en;
    assign mem_waddr   = spr_idx[ADDR_W-1:0];
    assign mem_wdata   = host_wdata[7:0];
    assign mem_raddr   = pf_load ? host_wdata[ADDR_W-1:0] : spr_idx[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            spr_en     <= 1'b0;
            wr_err     <= 1'b0;
            spr_idx    <= '0;
            pos_x      <= '0;
            pos_y      <= '0;
            hot_x      <= '0;
            hot_y      <= '0;
            col0       <= '0;
            col1       <= '0;
            prefetch   <= '0;
            host_rdata <= '0;
        end else if (host_we) begin
            unique case (host_addr)
                A_POS_X: pos_x <= host_wdata[COORD_W-1:0];
                A_POS_Y: pos_y <= host_wdata[COORD_W-1:0];
                A_HOT_X: hot_x <= host_wdata[HOT_W-1:0];
                A_HOT_Y: hot_y <= host_wdata[HOT_W-1:0];
                A_CTRL: begin
                    spr_en <= host_wdata[0];
                    if (host_wdata[1]) begin
                        wr_err <= 1'b0;
                    end
                end
                A_C0_R: col0.r <= host_wdata[7:0];
                A_C0_G: col0.g <= host_wdata[7:0];
                A_C0_B: col0.b <= host_wdata[7:0];
                A_C1_R: col1.r <= host_wdata[7:0];
                A_C1_G: col1.g <= host_wdata[7:0];
                A_C1_B: col1.b <= host_wdata[7:0];
                A_INDEX: spr_idx <= host_wdata[IDX_W-1:0];
                A_INDEX_PF: begin
                    spr_idx  <= host_wdata[IDX_W-1:0];
                    prefetch <= mem_rbyte;
                end
                A_DATA: begin
                    if (spr_en) begin
                        wr_err <= 1'b1;
                    end else begin
                        spr_idx <= spr_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (host_re) begin
            unique case (host_addr)
                A_DATA: begin
                    host_rdata <= mem_rbyte;
                    spr_idx    <= spr_idx + 1'b1;
                end
                A_PREFETCH: host_rdata <= prefetch;
                A_CTRL:     host_rdata <= {6'd0, wr_err, spr_en};
                default:    host_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
    import cursor_ovl_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int SPR_DIM = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spr_en,
    input  logic [COORD_W-1:0]          pos_x,
    input  logic [COORD_W-1:0]          pos_y,
    input  logic [$clog2(SPR_DIM)-1:0]  hot_x,
    input  logic [$clog2(SPR_DIM)-1:0]  hot_y,
    input  rgb_t                        col0,
    input  rgb_t                        col1,
    input  logic                        pix_valid,
    input  logic [COORD_W-1:0]          beam_x,
    input  logic [COORD_W-1:0]          beam_y,
    input  rgb_t                        pix_in,
    output logic [2*$clog2(SPR_DIM)-3:0] bm_addr,
    input  logic [7:0]                  bm_byte,
    output logic                        out_valid,
    output rgb_t                        out_pix
);
    localparam int LOG_DIM = $clog2(SPR_DIM);
    localparam int DW      = COORD_W + 2;

    logic signed [DW-1:0] dx;
    logic signed [DW-1:0] dy;
    logic                 hit;
    spr_code_e            code;
    rgb_t                 mixed;

    function automatic logic signed [DW-1:0] offset(
        input logic [COORD_W-1:0] beam,
        input logic [COORD_W-1:0] pos,
        input logic [LOG_DIM-1:0] hot
    );
        logic signed [DW-1:0] edge_v;
        edge_v = $signed({2'b00, pos}) - $signed(DW'(hot));
        return $signed({2'b00, beam}) - edge_v;
    endfunction

    assign dx  = offset(beam_x, pos_x, hot_x);
    assign dy  = offset(beam_y, pos_y, hot_y);
    assign hit = !dx[DW-1] && !dy[DW-1]
              && (dx < $signed(DW'(SPR_DIM))) && (dy < $signed(DW'(SPR_DIM)));

    assign bm_addr = {dy[LOG_DIM-1:0], dx[LOG_DIM-1:2]};
    assign code    = spr_code_e'(bm_byte[2*dx[1:0] +: 2]);

    always_comb begin
        mixed = pix_in;
        if (spr_en && pix_valid && hit) begin
            unique case (code)
                CODE_C0:     mixed = col0;
                CODE_C1:     mixed = col1;
                CODE_CLEAR:  mixed = pix_in;
                CODE_INVERT: mixed = rgb_invert(pix_in);
                default:     mixed = pix_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_pix   <= mixed;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_ovl_pkg::*;
#(
    parameter int SPR_DIM = 64,
    parameter int COORD_W = 11,
    parameter int IDX_W   = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [3:0]         host_addr,
    input  logic [15:0]        host_wdata,
    output logic [7:0]         host_rdata,
    output logic               wr_err,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [23:0]        pix_rgb,
    output logic               out_valid,
    output logic [23:0]        out_rgb
);
    localparam int HOT_W  = $clog2(SPR_DIM);
    localparam int ADDR_W = 2 * HOT_W - 2;

    logic               spr_en;
    logic [IDX_W-1:0]   spr_idx;
    logic [COORD_W-1:0] pos_x, pos_y;
    logic [HOT_W-1:0]   hot_x, hot_y;
    rgb_t               col0, col1;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr, mem_raddr, pix_addr;
    logic [7:0]         mem_wdata, mem_rbyte, pix_byte;
    rgb_t               out_pix;

    cursor_host_regs #(
        .COORD_W(COORD_W), .HOT_W(HOT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .wr_err(wr_err),
        .spr_en(spr_en), .spr_idx(spr_idx),
        .pos_x(pos_x), .pos_y(pos_y), .hot_x(hot_x), .hot_y(hot_y),
        .col0(col0), .col1(col1),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .mem_rbyte(mem_rbyte)
    );

    cursor_bitmap #(.ADDR_W(ADDR_W)) u_bitmap (
        .clk(clk),
        .wr_en(mem_we), .wr_addr(mem_waddr), .wr_byte(mem_wdata),
        .pix_addr(pix_addr), .pix_byte(pix_byte),
        .host_addr(mem_raddr), .host_byte(mem_rbyte)
    );

    cursor_mixer #(.COORD_W(COORD_W), .SPR_DIM(SPR_DIM)) u_mixer (
        .clk(clk), .rst(rst), .spr_en(spr_en),
        .pos_x(pos_x), .pos_y(pos_y), .hot_x(hot_x), .hot_y(hot_y),
        .col0(col0), .col1(col1),
        .pix_valid(pix_valid), .beam_x(beam_x), .beam_y(beam_y),
        .pix_in(rgb_t'(pix_rgb)),
        .bm_addr(pix_addr), .bm_byte(pix_byte),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    assign out_rgb = out_pix;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_ovl_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic [3:0]       host_addr,
    input logic [15:0]      host_wdata,
    input logic             pix_valid,
    input logic [23:0]      pix_rgb,
    input logic             out_valid,
    input logic [23:0]      out_rgb,
    input logic             wr_err,
    input logic             spr_en,
    input logic [IDX_W-1:0] spr_idx
);
    logic wr_data;
    logic err_clear;

    assign wr_data   = host_we && (host_addr == 4'(A_DATA));
    assign err_clear = host_we && (host_addr == 4'(A_CTRL)) && host_wdata[1];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid); // R2
    AST_INVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid); // R11
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
        !spr_en |=> (out_rgb == $past(pix_rgb))); // R2
    AST_INVALID_PASS: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> (out_rgb == $past(pix_rgb))); // R11
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !spr_en) |=> (spr_idx == $past(spr_idx) + 1'b1)); // R6
    AST_BLOCKED_IDX: assert property (@(posedge clk) disable iff (rst)
        (wr_data && spr_en) |=> $stable(spr_idx)); // R9
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_data && spr_en) |=> wr_err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wr_err && !err_clear) |=> wr_err); // R9
endmodule

bind cursor_overlay cursor_overlay_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb), .wr_err(wr_err),
    .spr_en(spr_en), .spr_idx(spr_idx)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        wr_err;
    logic        pix_valid = 1'b0;
    logic [10:0] beam_x = '0, beam_y = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  spr [1024];
    int          px, py, hx, hy;
    logic        en_m;
    logic [23:0] c0_m, c1_m;

    always #10 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .wr_err(wr_err), .pix_valid(pix_valid), .beam_x(beam_x), .beam_y(beam_y),
        .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // vector: {x, y, pixel}
    localparam logic [45:0] VEC [12] = '{
        {11'd95,  11'd47,  24'h123456},
        {11'd96,  11'd47,  24'hA0B0C0},
        {11'd97,  11'd47,  24'h0F1E2D},
        {11'd98,  11'd47,  24'h55AA33},
        {11'd94,  11'd47,  24'h777777},
        {11'd158, 11'd47,  24'h010203},
        {11'd159, 11'd47,  24'h0A0B0C},
        {11'd95,  11'd46,  24'hFEDCBA},
        {11'd95,  11'd110, 24'h314159},
        {11'd95,  11'd111, 24'h271828},
        {11'd120, 11'd80,  24'h00FF00},
        {11'd131, 11'd99,  24'hC0FFEE}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [23:0] model(input int x, input int y, input logic [23:0] p);
        int dx, dy;
        logic [1:0] c;
        dx = x - (px - hx);
        dy = y - (py - hy);
        if (!en_m || dx < 0 || dy < 0 || dx > 63 || dy > 63) return p;
        c = spr[dy*16 + dx/4][2*(dx%4) +: 2];
        case (c)
            2'd0: return c0_m;
            2'd1: return c1_m;
            2'd2: return p;
            default: return ~p;
        endcase
    endfunction

    task automatic pixel(input string req, input int x, input int y,
                         input logic [23:0] p, input logic v);
        @(negedge clk);
        pix_valid = v; beam_x = 11'(x); beam_y = 11'(y); pix_rgb = p;
        @(negedge clk);
        check(req, {31'd0, out_valid}, {31'd0, v});
        check(req, {8'd0, out_rgb}, {8'd0, v ? model(x, y, p) : p});
        pix_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        en_m = 1'b0; px = 100; py = 50; hx = 5; hy = 3;
        c0_m = 24'h112233; c1_m = 24'hE0C0A0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {8'd0, out_rgb}, 32'd0);
        check("R1", {31'd0, wr_err}, 32'd0);
        rd(4'd4, d);
        check("R1", {24'd0, d}, 32'd0);

        // R10 map: position, hotspot, colours
        wr(4'd0, 16'(px)); wr(4'd1, 16'(py)); wr(4'd2, 16'(hx)); wr(4'd3, 16'(hy));
        wr(4'd5, 16'h11); wr(4'd6, 16'h22); wr(4'd7, 16'h33);
        wr(4'd8, 16'hE0); wr(4'd9, 16'hC0); wr(4'd10, 16'hA0);

        // R6 load full bitmap
        for (int i = 0; i < 1024; i++) spr[i] = 8'((i * 37 + 11) & 255);
        spr[0] = 8'hE4;
        wr(4'd11, 16'd0);
        for (int i = 0; i < 1024; i++) wr(4'd13, {8'd0, spr[i]});
        // R6 top of memory: two sequential writes
        wr(4'd11, 16'd1022);
        wr(4'd13, 16'h00A1); wr(4'd13, 16'h00A2);
        spr[1022] = 8'hA1; spr[1023] = 8'hA2;
        wr(4'd11, 16'd1022);
        rd(4'd13, d); check("R6", {24'd0, d}, 32'hA1);
        // R7 read advances index
        rd(4'd13, d); check("R7", {24'd0, d}, 32'hA2);
        wr(4'd11, 16'd5);
        rd(4'd13, d); check("R7", {24'd0, d}, {24'd0, spr[5]});
        rd(4'd13, d); check("R7", {24'd0, d}, {24'd0, spr[6]});
        // R8 prefetch
        wr(4'd12, 16'd300);
        rd(4'd14, d); check("R8", {24'd0, d}, {24'd0, spr[300]});
        rd(4'd13, d); check("R8", {24'd0, d}, {24'd0, spr[300]});

        // R2 disabled pass-through over the cursor
        pixel("R2", 95, 47, 24'h123456, 1'b1);

        // enable and read back (R10)
        wr(4'd11, 16'd0);
        wr(4'd4, 16'h0001); en_m = 1'b1;
        rd(4'd4, d); check("R10", {24'd0, d}, 32'd1);

        // R3 R4 R5 table walk
        for (int i = 0; i < 12; i++)
            pixel("R3/R4/R5", int'(VEC[i][45:35]), int'(VEC[i][34:24]), VEC[i][23:0], 1'b1);

        // R11 invalid pixel over cursor passes through
        pixel("R11", 95, 47, 24'h445566, 1'b0);

        // R9 refused write while enabled
        wr(4'd13, 16'h0000);
        check("R9", {31'd0, wr_err}, 32'd1);
        wr(4'd4, 16'h0000); en_m = 1'b0;
        check("R9", {31'd0, wr_err}, 32'd1);
        rd(4'd13, d); check("R9", {24'd0, d}, 32'hE4);
        wr(4'd4, 16'h0002);
        check("R9", {31'd0, wr_err}, 32'd0);

        // R3 negative left edge
        wr(4'd4, 16'h0001); en_m = 1'b1;
        px = 2; hx = 10;
        wr(4'd0, 16'd2); wr(4'd2, 16'd10);
        pixel("R3", 0, 47, 24'h98BADC, 1'b1);
        pixel("R3", 55, 47, 24'h13579B, 1'b1);
        pixel("R3", 56, 47, 24'h2468AC, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule